// File: doc/BRIEF.md
# Fractional UART Baud Rate Generator

This block turns a peripheral clock into the two timing strobes a UART needs: a sample tick at the oversampling rate and a bit tick at the serial bit rate. The sample tick period comes from a 16-bit integer divisor. A pair of 4-bit fields, an addend and a modulus, can stretch that period. Over many periods the average stretch equals one plus the addend divided by the modulus. An overflow accumulator picks which sample periods run at double length.

The number of sample ticks per bit is also programmable. It is a 4-bit integer field plus one, with a 2-bit field that adds a fraction in eighths. Each bit lasts either the integer count of samples or one sample more. An eighths accumulator decides which. The resulting bit rate is clock / (ratio × divisor × (1 + addend/modulus)). A receiver uses the sample tick to oversample the line, and a transmitter uses the bit tick to shift out data. The configuration is held on plain input pins. Any change to any field restarts every internal counter and accumulator from zero.

Top module: `fracbaud_gen`

## Requirements
- R1: While `rst_n` is low, `sample_tick` and `bit_tick` are both 0.
- R2: With the fraction disabled, `sample_tick` is a one-clock pulse every D clocks, where D = 256·`div_hi` + `div_lo`. The first pulse comes D clocks after the clock edge at which a new configuration is taken.
- R3: A divisor of 0 behaves exactly like a divisor of 1, so `sample_tick` is high on every clock.
- R4: `frac_cfg` packs the addend A in bits 3:0 and the modulus M in bits 7:4. When the fraction is enabled, an accumulator starts at 0 and adds A at the end of each base period of D clocks. If the sum is M or more, M is subtracted and that sample period lasts 2·D clocks. Otherwise it lasts D clocks.
- R5: The fraction is disabled when A is 0, when M is 0, or when A is M or more. In that case the addend and modulus have no effect on the tick timing.
- R6: A bit lasts N = `os_int` + 1 sample ticks, plus one extra sample tick whenever an eighths accumulator (starting at 0) plus `os_frac` reaches 8 or more. When that happens, 8 is subtracted. `bit_tick` is raised in the same clock as the sample tick that ends the bit.
- R7: Starting from a restart, the 8·M-th `bit_tick` comes exactly D·(M+A)·(8N+F) clocks after the restart edge, where F = `os_frac`. A disabled fraction counts as M=1, A=0.
- R8: Any change to any configuration input restarts all counters and accumulators. In the clock after the restart edge neither tick is high.
- R9: `bit_tick` is never high without `sample_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_lo | input | 8 | Low byte of the integer divisor |
| div_hi | input | 8 | High byte of the integer divisor |
| frac_cfg | input | 8 | Fraction addend in bits 3:0, modulus in bits 7:4 |
| os_int | input | 4 | Samples per bit minus one |
| os_frac | input | 2 | Extra eighths of a sample per bit |
| sample_tick | output | 1 | One-clock oversampling strobe |
| bit_tick | output | 1 | One-clock bit strobe, coincident with a sample tick |

## Verification
The assertions assume the configuration pins change only between clock edges. They also assume that a change is meant as a restart, and they do not constrain out-of-range fraction fields, since those are defined as disabled.

The stimulus draws random divisors, addends, moduli and oversampling fields from a fixed seed, including zero divisors, zero moduli and addends at or above the modulus. Small divisors keep the exact long-run cycle counts short. Before every new setting the bench drives a deliberately different setting for one clock, so a restart always takes place even when a random draw repeats the previous setting.

// File: rtl/fracbaud_pkg.sv
`timescale 1ns/1ps
package fracbaud_pkg;
    parameter int DIV_W  = 16;
    parameter int FRAC_W = 4;
    parameter int OSI_W  = 4;
    parameter int OSF_W  = 2;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [FRAC_W-1:0] add;
        logic [FRAC_W-1:0] mul;
        logic [OSI_W-1:0]  osi;
        logic [OSF_W-1:0]  osf;
    } bg_cfg_t;
endpackage

// File: rtl/bg_prescale.sv
`timescale 1ns/1ps
module bg_prescale #(
    parameter int DW = 16,
    parameter int FW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [DW-1:0] div,
    input  logic [FW-1:0] add,
    input  logic [FW-1:0] mul,
    output logic          sample_end,
    output logic          sample_tick
);
    typedef struct packed {
        logic [DW-1:0] pc;
        logic          seg;
        logic [FW-1:0] acc;
        logic          tick;
    } ps_state_t;

    ps_state_t st_d, st_q;
    logic [DW-1:0] lim;
    logic          frac_en;
    logic [FW:0]   sum;
    logic          strobe;

    always_comb begin
        st_d    = st_q;
        strobe  = 1'b0;
        lim     = (div == '0) ? '0 : div - 1'b1;
        frac_en = (add != '0) && (mul != '0) && (add < mul);
        sum     = {1'b0, st_q.acc} + {1'b0, add};
        if (restart) begin
            st_d = '0;
        end else if (st_q.pc == lim) begin
            st_d.pc = '0;
            if (st_q.seg) begin
                st_d.seg = 1'b0;
                strobe   = 1'b1;
            end else if (frac_en && (sum >= {1'b0, mul})) begin
                st_d.acc = FW'(sum - {1'b0, mul});
                st_d.seg = 1'b1;
            end else begin
                if (frac_en) st_d.acc = FW'(sum);
                strobe = 1'b1;
            end
        end else begin
            st_d.pc = st_q.pc + 1'b1;
        end
        st_d.tick = strobe;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sample_end  = strobe;
    assign sample_tick = st_q.tick;

    // R4: the carried remainder stays below the modulus
    assert_acc_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frac_en && !restart) |-> (st_q.acc < mul));
    // R2: with a divisor above one, a tick never repeats on the next clock
    assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.tick && (div > 1) && !restart) |=> !st_q.tick);
endmodule

// File: rtl/bg_oversample.sv
`timescale 1ns/1ps
module bg_oversample #(
    parameter int IW = 4,
    parameter int FW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          sample_end,
    input  logic [IW-1:0] osi,
    input  logic [FW-1:0] osf,
    output logic          bit_tick
);
    localparam int AW = FW + 1;

    typedef struct packed {
        logic [IW-1:0] sc;
        logic          xph;
        logic [AW-1:0] acc8;
        logic          tick;
    } os_state_t;

    os_state_t st_d, st_q;
    logic [AW:0] sum8;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        sum8      = {1'b0, st_q.acc8} + (AW+1)'(osf);
        if (restart) begin
            st_d = '0;
        end else if (sample_end) begin
            if (st_q.xph) begin
                st_d.xph  = 1'b0;
                st_d.tick = 1'b1;
            end else if (st_q.sc == osi) begin
                st_d.sc   = '0;
                st_d.acc8 = sum8[AW-1:0];
                if (sum8[AW]) st_d.xph  = 1'b1;
                else          st_d.tick = 1'b1;
            end else begin
                st_d.sc = st_q.sc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_tick = st_q.tick;

    // R6: no extra sample phase is ever entered when no eighths are asked for
    assert_no_extra_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((osf == '0) && !restart) |-> !st_q.xph);
endmodule

// File: rtl/fracbaud_gen.sv
`timescale 1ns/1ps
module fracbaud_gen
    import fracbaud_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] div_lo,
    input  logic [7:0] div_hi,
    input  logic [7:0] frac_cfg,
    input  logic [3:0] os_int,
    input  logic [1:0] os_frac,
    output logic       sample_tick,
    output logic       bit_tick
);
    bg_cfg_t cfg_in, cfg_d, cfg_q;
    logic    restart;
    logic    sample_end;

    always_comb begin
        cfg_in.div = {div_hi, div_lo};
        cfg_in.add = frac_cfg[3:0];
        cfg_in.mul = frac_cfg[7:4];
        cfg_in.osi = os_int;
        cfg_in.osf = os_frac;
        restart    = (cfg_in != cfg_q);
        cfg_d      = cfg_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    bg_prescale #(.DW(DIV_W), .FW(FRAC_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .div(cfg_in.div), .add(cfg_in.add), .mul(cfg_in.mul),
        .sample_end(sample_end), .sample_tick(sample_tick)
    );

    bg_oversample #(.IW(OSI_W), .FW(OSF_W)) u_os (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .sample_end(sample_end), .osi(cfg_in.osi), .osf(cfg_in.osf),
        .bit_tick(bit_tick)
    );

    // R9: bit strobe only together with a sample strobe
    assert_bit_with_sample_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> sample_tick);
    // R8: a restart leaves both strobes low in the following clock
    assert_restart_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!sample_tick && !bit_tick));
endmodule

// File: tb/tb_fracbaud_gen.sv
`timescale 1ns/1ps
module tb_fracbaud_gen;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] div_lo = 8'd1, div_hi = 8'd0, frac_cfg = 8'h00;
    logic [3:0] os_int = 4'd15;
    logic [1:0] os_frac = 2'd0;
    logic sample_tick, bit_tick;

    int checks = 0, fails = 0;
    int cyc = 0;

    fracbaud_gen dut (
        .clk(clk), .rst_n(rst_n), .div_lo(div_lo), .div_hi(div_hi),
        .frac_cfg(frac_cfg), .os_int(os_int), .os_frac(os_frac),
        .sample_tick(sample_tick), .bit_tick(bit_tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int eff_div(int lo, int hi);
        int d = hi * 256 + lo;
        return (d == 0) ? 1 : d;
    endfunction

    function automatic bit frac_on(int a, int m);
        return (a != 0) && (m != 0) && (a < m);
    endfunction

    task automatic report(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // apply a setting, forcing a restart even if it repeats the last one
    task automatic apply(int lo, int hi, int fc, int oi, int of);
        @(negedge clk);
        div_hi = ~hi[7:0]; div_lo = lo[7:0];
        @(negedge clk);
        div_lo = lo[7:0]; div_hi = hi[7:0]; frac_cfg = fc[7:0];
        os_int = oi[3:0]; os_frac = of[1:0];
        @(posedge clk);
    endtask

    // R2 R3 R4 R5 R6 R8: per-interval timing against the requirement model
    task automatic run_seq(int lo, int hi, int fc, int oi, int of, int nsamp, string req);
        int d = eff_div(lo, hi);
        int a = fc & 15;
        int m = (fc >> 4) & 15;
        int racc = 0, r8 = 0, rsc = 0;
        bit rx = 0;
        apply(lo, hi, fc, oi, of);
        for (int s = 0; s < nsamp; s++) begin
            bit ext = 0;
            bit eb = 0;
            int len;
            int bad = 0, bad_act = 0, bad_exp = 0;
            if (frac_on(a, m)) begin
                if (racc + a >= m) begin ext = 1; racc = racc + a - m; end
                else racc = racc + a;
            end
            len = ext ? 2 * d : d;
            if (rx) begin rx = 0; eb = 1; end
            else if (rsc == oi) begin
                rsc = 0;
                if (r8 + of >= 8) begin r8 = r8 + of - 8; rx = 1; end
                else begin r8 = r8 + of; eb = 1; end
            end else rsc++;
            for (int i = 0; i < len; i++) begin
                int got, want;
                @(posedge clk); #1;
                got  = {30'd0, sample_tick, bit_tick};
                want = (i == len - 1) ? (eb ? 3 : 2) : 0;
                if (got != want && !bad) begin bad = 1; bad_act = got; bad_exp = want; end
            end
            report(!bad, req, bad_act, bad_exp);
        end
    endtask

    // R7: exact cycle count to the 8*M-th bit tick
    task automatic run_avg(int lo, int fc, int oi, int of);
        int d = eff_div(lo, 0);
        int a = fc & 15;
        int m = (fc >> 4) & 15;
        int k, exp_c, cnt = 0, nb = 0;
        if (!frac_on(a, m)) begin a = 0; m = 1; end
        k = 8 * m;
        exp_c = d * (m + a) * (8 * (oi + 1) + of);
        apply(lo, 0, fc, oi, of);
        while (nb < k && cnt < exp_c + 10) begin
            @(posedge clk); #1;
            cnt++;
            if (bit_tick) nb++;
        end
        report(cnt == exp_c, "R7", cnt, exp_c);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin : main
        int seed = 1234;
        void'($urandom(seed));
        // R1: reset state
        repeat (4) begin
            @(negedge clk);
            report(!sample_tick && !bit_tick, "R1", {sample_tick, bit_tick}, 0);
        end
        rst_n = 1'b1;

        // directed corners
        run_seq(5, 0, 8'h00, 3, 0, 12, "R2");
        run_seq(0, 0, 8'h00, 2, 0, 10, "R3");
        run_seq(2, 0, 8'h31, 3, 0, 12, "R4");   // A=1 M=3
        run_seq(3, 0, 8'h54, 1, 0, 12, "R4");   // A=4 M=5
        run_seq(3, 0, 8'h0A, 1, 0, 8, "R5");    // M=0
        run_seq(3, 0, 8'h55, 1, 0, 8, "R5");    // A=M
        run_seq(2, 0, 8'h00, 1, 3, 24, "R6");
        run_seq(1, 0, 8'h00, 0, 3, 16, "R6");
        run_seq(0, 1, 8'h00, 0, 0, 3, "R8");    // divisor 256
        run_avg(2, 8'h32, 3, 3);
        run_avg(1, 8'hFE, 1, 1);
        run_avg(0, 8'h00, 15, 0);

        // constrained random mix
        for (int t = 0; t < 14; t++) begin
            int lo = $urandom % 5;
            int fc = $urandom % 256;
            int oi = $urandom % 16;
            int of = $urandom % 4;
            run_seq(lo, 0, fc, oi, of, 30, "R4");
        end
        for (int t = 0; t < 3; t++) begin
            run_avg($urandom % 3, $urandom % 256, $urandom % 8, $urandom % 4);
        end

        // R9: bit tick only with sample tick during a free run
        apply(1, 0, 8'h21, 0, 2);
        begin
            int bad = 0;
            for (int i = 0; i < 200; i++) begin
                @(posedge clk); #1;
                if (bit_tick && !sample_tick) bad++;
            end
            report(bad == 0, "R9", bad, 0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule